// File: doc/BRIEF.md
# Fetch-Stage Dynamic Branch Predictor

This block sits beside the fetch stage and guesses, in the same cycle the fetch address is presented, whether the instruction there is a branch that will be taken and where it will go. A direction table of small per-entry state machines is selected by low address bits. A separate direct-mapped target cache, tagged with the upper address bits, supplies the destination. Fetch can therefore be steered to a taken target with no bubble whenever both agree.

When the back end resolves a branch it reports the branch address, the real outcome, the real destination and whether the earlier guess was wrong. The direction entry and, for taken branches, the target cache entry are rewritten on the next clock edge. A parameter chooses per build between a one-bit scheme that inverts its guess after every miss and a two-bit saturating scheme that needs two consecutive misses to change direction. Unrelated branches that share low address bits share a direction entry. That only costs accuracy.

Top module: `branch_predictor`

## Requirements
- R1: A synchronous reset clears every target-cache valid flag and puts every direction entry in its strongest not-taken state, so after reset every address predicts not taken with no target.
- R2: The direction entry is selected by address bits [OFS_W+IDX_W-1:OFS_W] (bits 5:2 by default). Two addresses that agree in those bits share one entry and see each other's training.
- R3: In two-bit mode each entry is a counter that steps up on a taken outcome, saturating at 3, and steps down on a not-taken outcome, saturating at 0. It predicts taken when the count is 2 or 3.
- R4: In one-bit mode an update with upd_mispredict high inverts the stored guess, and an update with upd_mispredict low leaves it unchanged, whatever upd_taken says.
- R5: In two-bit mode upd_mispredict has no effect; only upd_taken steers the counter.
- R6: A valid update with upd_taken high stores upd_target, with a tag of address bits [PC_W-1:OFS_W+TGT_IDX_W], in the target-cache entry at bits [OFS_W+TGT_IDX_W-1:OFS_W] (bits 4:2 by default). A lookup hits only when that entry is valid and its tag equals the lookup address tag.
- R7: pred_tgt_valid is high only when pred_taken is high and the target cache hits. pred_tgt then carries the stored target and is zero otherwise.
- R8: A lookup and an update of the same entry in the same cycle return the state from before the update. The new state is visible from the following cycle.
- R9: For a loop branch taken nine times and then not taken, a warmed second pass of ten outcomes gives two mispredictions in one-bit mode and one in two-bit mode.
- R10: With upd_valid low, no field of the update port changes any prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pred_pc | input | PC_W | Fetch address to predict |
| pred_taken | output | 1 | Guess that the branch is taken |
| pred_tgt_valid | output | 1 | Taken guess with a matching cached target |
| pred_tgt | output | PC_W | Cached target, zero when not valid |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome |
| upd_target | input | PC_W | Actual destination |
| upd_mispredict | input | 1 | The earlier guess for this branch was wrong |

## Verification
The bench walks a two-bit entry through every counter value, including both saturation points. A design with a wrapping or off-by-one counter would predict taken one step too early or flip after a single miss from a strong state. It trains an address and then looks up an alias that shares its direction entry and target-cache slot but not its tag. A predictor that skipped the tag compare would hand out a foreign target, and one that indexed with the wrong bits would lose the shared direction. It presents a lookup and an update of one entry in the same cycle, which catches a write-through bypass. It also replays the loop pattern in both modes side by side, where a one-bit table that ignored the mispredict flag, or a two-bit table that honoured it, would give the wrong miss counts.

// File: rtl/bp_pkg.sv
package bp_pkg;

    // Strongest not-taken counter value, used at reset.
    localparam logic [1:0] CTR_STRONG_NT = 2'b00;
    localparam logic [1:0] CTR_STRONG_T  = 2'b11;

    // Saturating step of a two-bit direction counter.
    function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
        logic [1:0] nxt;
        if (taken) begin
            nxt = (cur == CTR_STRONG_T) ? cur : cur + 2'd1;
        end else begin
            nxt = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/bp_dir_table.sv
module bp_dir_table #(
    parameter int IDX_W   = 4,
    parameter bit TWO_BIT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken,
    input  logic             wr_mispredict
);
    localparam int ENTRIES = 1 << IDX_W;

    typedef struct packed {
        logic [ENTRIES-1:0][1:0] ctr;
    } dir_state_t;

    dir_state_t st_d, st_q;
    logic [1:0] entry_nxt;

    generate
        if (TWO_BIT) begin : g_two_bit
            // Outcome alone drives the saturating counter.
            logic unused_mis;
            assign unused_mis = wr_mispredict;
            assign entry_nxt  = bp_pkg::ctr_step(st_q.ctr[wr_idx], wr_taken);
        end else begin : g_one_bit
            // Both bits mirror one guess bit; a miss inverts it.
            logic unused_taken;
            logic flipped;
            assign unused_taken = wr_taken;
            assign flipped      = st_q.ctr[wr_idx][0] ^ wr_mispredict;
            assign entry_nxt    = {2{flipped}};
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.ctr = {ENTRIES{bp_pkg::CTR_STRONG_NT}};
        end else if (wr_en) begin
            st_d.ctr[wr_idx] = entry_nxt;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rd_taken = st_q.ctr[rd_idx][1];

endmodule

// File: rtl/bp_tgt_buf.sv
module bp_tgt_buf #(
    parameter int PC_W  = 32,
    parameter int OFS_W = 2,
    parameter int IDX_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] rd_pc,
    output logic            rd_hit,
    output logic [PC_W-1:0] rd_tgt,
    input  logic            wr_en,
    input  logic [PC_W-1:0] wr_pc,
    input  logic [PC_W-1:0] wr_tgt
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam int TAG_LSB = OFS_W + IDX_W;
    localparam int TAG_W   = PC_W - TAG_LSB;

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic [PC_W-1:0]  tgt;
    } btb_ent_t;

    typedef struct packed {
        btb_ent_t [ENTRIES-1:0] ent;
    } btb_state_t;

    btb_state_t st_d, st_q;

    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic [TAG_W-1:0] rd_tag, wr_tag;
    logic [OFS_W-1:0] unused_rd_ofs, unused_wr_ofs;

    assign rd_idx        = rd_pc[OFS_W +: IDX_W];
    assign rd_tag        = rd_pc[PC_W-1:TAG_LSB];
    assign wr_idx        = wr_pc[OFS_W +: IDX_W];
    assign wr_tag        = wr_pc[PC_W-1:TAG_LSB];
    assign unused_rd_ofs = rd_pc[OFS_W-1:0];
    assign unused_wr_ofs = wr_pc[OFS_W-1:0];

    always_comb begin
        st_d = st_q;
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                st_d.ent[i].vld = 1'b0;
            end
        end else if (wr_en) begin
            st_d.ent[wr_idx].vld = 1'b1;
            st_d.ent[wr_idx].tag = wr_tag;
            st_d.ent[wr_idx].tgt = wr_tgt;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rd_hit = st_q.ent[rd_idx].vld && (st_q.ent[rd_idx].tag == rd_tag);
    assign rd_tgt = st_q.ent[rd_idx].tgt;

endmodule

// File: rtl/branch_predictor.sv
module branch_predictor #(
    parameter int PC_W      = 32,
    parameter int OFS_W     = 2,
    parameter int IDX_W     = 4,
    parameter int TGT_IDX_W = 3,
    parameter bit TWO_BIT   = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    output logic            pred_tgt_valid,
    output logic [PC_W-1:0] pred_tgt,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target,
    input  logic            upd_mispredict
);
    logic            dir_taken;
    logic            btb_hit;
    logic [PC_W-1:0] btb_tgt;

    bp_dir_table #(
        .IDX_W   (IDX_W),
        .TWO_BIT (TWO_BIT)
    ) u_dir (
        .clk           (clk),
        .rst           (rst),
        .rd_idx        (pred_pc[OFS_W +: IDX_W]),
        .rd_taken      (dir_taken),
        .wr_en         (upd_valid),
        .wr_idx        (upd_pc[OFS_W +: IDX_W]),
        .wr_taken      (upd_taken),
        .wr_mispredict (upd_mispredict)
    );

    bp_tgt_buf #(
        .PC_W  (PC_W),
        .OFS_W (OFS_W),
        .IDX_W (TGT_IDX_W)
    ) u_btb (
        .clk    (clk),
        .rst    (rst),
        .rd_pc  (pred_pc),
        .rd_hit (btb_hit),
        .rd_tgt (btb_tgt),
        .wr_en  (upd_valid & upd_taken),
        .wr_pc  (upd_pc),
        .wr_tgt (upd_target)
    );

    assign pred_taken     = dir_taken;
    assign pred_tgt_valid = dir_taken & btb_hit;
    assign pred_tgt       = pred_tgt_valid ? btb_tgt : '0;

endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
    parameter int PC_W    = 32,
    parameter bit TWO_BIT = 1'b1
) (
    input logic            clk,
    input logic            rst,
    input logic [PC_W-1:0] pred_pc,
    input logic            pred_taken,
    input logic            pred_tgt_valid,
    input logic [PC_W-1:0] pred_tgt,
    input logic            upd_valid,
    input logic [PC_W-1:0] upd_pc,
    input logic            upd_taken
);
    // R1
    after_reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pred_taken && !pred_tgt_valid));

    // R7
    tgt_needs_taken_chk: assert property (@(posedge clk) disable iff (rst)
        pred_tgt_valid |-> pred_taken);

    // R7
    tgt_zero_when_invalid_chk: assert property (@(posedge clk) disable iff (rst)
        !pred_tgt_valid |-> (pred_tgt == '0));

    // R10
    idle_holds_prediction_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(upd_valid) && $stable(pred_pc))
        |-> ($stable(pred_taken) && $stable(pred_tgt_valid) && $stable(pred_tgt)));

    generate
        if (TWO_BIT) begin : g_two_bit_chk
            // R3
            taken_stays_taken_chk: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(upd_valid && upd_taken && (upd_pc == pred_pc) && pred_taken)
                 && $stable(pred_pc)) |-> pred_taken);

            // R3
            nt_stays_nt_chk: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(upd_valid && !upd_taken && (upd_pc == pred_pc) && !pred_taken)
                 && $stable(pred_pc)) |-> !pred_taken);
        end
    endgenerate

endmodule

bind branch_predictor bp_checker #(
    .PC_W    (PC_W),
    .TWO_BIT (TWO_BIT)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .pred_pc        (pred_pc),
    .pred_taken     (pred_taken),
    .pred_tgt_valid (pred_tgt_valid),
    .pred_tgt       (pred_tgt),
    .upd_valid      (upd_valid),
    .upd_pc         (upd_pc),
    .upd_taken      (upd_taken)
);

// File: tb/tb_branch_predictor.sv
`timescale 1ns/1ps
module tb_branch_predictor;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pred_pc = '0;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;
    logic        upd_mispredict = 1'b0;

    logic        p2_taken, p2_tv, p1_taken, p1_tv;
    logic [31:0] p2_tgt, p1_tgt;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    branch_predictor #(.TWO_BIT(1'b1)) dut (
        .clk(clk), .rst(rst), .pred_pc(pred_pc),
        .pred_taken(p2_taken), .pred_tgt_valid(p2_tv), .pred_tgt(p2_tgt),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target), .upd_mispredict(upd_mispredict)
    );

    branch_predictor #(.TWO_BIT(1'b0)) dut_one (
        .clk(clk), .rst(rst), .pred_pc(pred_pc),
        .pred_taken(p1_taken), .pred_tgt_valid(p1_tv), .pred_tgt(p1_tgt),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target), .upd_mispredict(upd_mispredict)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge.
    task automatic do_upd(input logic [31:0] pc, input logic taken,
                          input logic [31:0] tgt, input logic mis);
        upd_valid = 1'b1; upd_pc = pc; upd_taken = taken;
        upd_target = tgt; upd_mispredict = mis;
        @(negedge clk);
        upd_valid = 1'b0; upd_mispredict = 1'b0;
    endtask

    task automatic look(input logic [31:0] pc);
        pred_pc = pc;
        #1;
    endtask

    task automatic t_reset;
        for (int i = 0; i < 4; i++) begin
            look(32'h0000_0100 + 32'(i * 4));
            chk("R1 taken2", {31'd0, p2_taken}, 32'd0);
            chk("R1 tv2", {31'd0, p2_tv}, 32'd0);
            chk("R1 taken1", {31'd0, p1_taken}, 32'd0);
            chk("R1 tgt1", p1_tgt, 32'd0);
        end
    endtask

    // R3 counter walk, R5 mispredict ignored (always high here), R6/R7 target.
    task automatic t_counter;
        logic [31:0] a = 32'h0000_1004;
        logic [31:0] t = 32'hCAFE_0040;
        do_upd(a, 1'b1, t, 1'b1); look(a);
        chk("R3 cnt1 nt", {31'd0, p2_taken}, 32'd0);
        chk("R7 no tgt when nt", {31'd0, p2_tv}, 32'd0);
        chk("R7 tgt zero", p2_tgt, 32'd0);
        do_upd(a, 1'b1, t, 1'b1); look(a);
        chk("R3 cnt2 t", {31'd0, p2_taken}, 32'd1);
        chk("R6 hit", {31'd0, p2_tv}, 32'd1);
        chk("R6 tgt", p2_tgt, t);
        do_upd(a, 1'b1, t, 1'b1);
        do_upd(a, 1'b1, t, 1'b1);
        do_upd(a, 1'b0, 32'd0, 1'b1); look(a);
        chk("R3 sat3 then 2", {31'd0, p2_taken}, 32'd1);
        do_upd(a, 1'b0, 32'd0, 1'b1); look(a);
        chk("R3 cnt1 nt again", {31'd0, p2_taken}, 32'd0);
        chk("R5 ignores mispredict", {31'd0, p2_tv}, 32'd0);
        do_upd(a, 1'b0, 32'd0, 1'b1);
        do_upd(a, 1'b0, 32'd0, 1'b1);
        do_upd(a, 1'b1, t, 1'b1); look(a);
        chk("R3 sat0 then 1", {31'd0, p2_taken}, 32'd0);
    endtask

    task automatic t_one_bit;
        logic [31:0] b = 32'h0000_2008;
        do_upd(b, 1'b1, 32'h0000_2200, 1'b1); look(b);
        chk("R4 flip to t", {31'd0, p1_taken}, 32'd1);
        do_upd(b, 1'b0, 32'd0, 1'b0); look(b);
        chk("R4 no flip", {31'd0, p1_taken}, 32'd1);
        do_upd(b, 1'b1, 32'h0000_2200, 1'b1); look(b);
        chk("R4 flip to nt", {31'd0, p1_taken}, 32'd0);
    endtask

    task automatic t_alias;
        logic [31:0] c  = 32'h0000_300C;
        logic [31:0] c2 = 32'h0000_304C;
        do_upd(c, 1'b1, 32'hAAAA_0000, 1'b0);
        do_upd(c, 1'b1, 32'hAAAA_0000, 1'b0);
        look(c);
        chk("R6 own hit", p2_tgt, 32'hAAAA_0000);
        look(c2);
        chk("R2 alias shares dir", {31'd0, p2_taken}, 32'd1);
        chk("R6 tag miss", {31'd0, p2_tv}, 32'd0);
        chk("R7 tag miss tgt", p2_tgt, 32'd0);
    endtask

    task automatic t_same_cycle;
        logic [31:0] d = 32'h0000_4014;
        do_upd(d, 1'b1, 32'h0000_5550, 1'b0);
        pred_pc = d;
        upd_valid = 1'b1; upd_pc = d; upd_taken = 1'b1;
        upd_target = 32'h0000_5550; upd_mispredict = 1'b0;
        #1;
        chk("R8 old value", {31'd0, p2_taken}, 32'd0);
        @(negedge clk);
        upd_valid = 1'b0;
        #1;
        chk("R8 new value", {31'd0, p2_taken}, 32'd1);
        chk("R8 new tgt", p2_tgt, 32'h0000_5550);
    endtask

    task automatic t_idle;
        logic [31:0] e = 32'h0000_5018;
        for (int i = 0; i < 3; i++) begin
            upd_valid = 1'b0; upd_pc = e; upd_taken = 1'b1;
            upd_target = 32'h0000_7000; upd_mispredict = 1'b1;
            @(negedge clk);
        end
        upd_mispredict = 1'b0;
        look(e);
        chk("R10 two-bit idle", {31'd0, p2_taken}, 32'd0);
        chk("R10 one-bit idle", {31'd0, p1_taken}, 32'd0);
        chk("R10 no tgt", {31'd0, p2_tv}, 32'd0);
    endtask

    task automatic t_loop;
        logic [31:0] l = 32'h0000_601C;
        int miss2 = 0;
        int miss1 = 0;
        for (int pass = 0; pass < 2; pass++) begin
            for (int k = 0; k < 10; k++) begin
                logic outcome;
                logic g1, g2;
                outcome = (k != 9);
                look(l);
                g1 = p1_taken; g2 = p2_taken;
                if (pass == 1) begin
                    if (g2 != outcome) miss2++;
                    if (g1 != outcome) miss1++;
                end
                do_upd(l, outcome, 32'h0000_6000, g1 != outcome);
            end
        end
        chk("R9 two-bit misses", 32'(miss2), 32'd1);
        chk("R9 one-bit misses", 32'(miss1), 32'd2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_counter();
        t_one_bit();
        t_alias();
        t_same_cycle();
        t_idle();
        t_loop();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule